// File: doc/BRIEF.md
# Tagged-Token Operand Matcher

This block pairs operands for a dynamic dataflow machine. Each incoming token carries a data value and a tag. The tag is a destination instruction address joined with a context number that names one loop iteration or one invocation. When a token is the only operand its instruction needs, it goes straight to the output as an enabled packet. A token for a two-operand instruction is compared against a small associative store of waiting operands. If the partner with the identical tag is already waiting, the two values are combined into one packet and the waiting entry is released. If no partner is waiting, the token is parked in the store.

Any number of tokens for the same instruction address may wait at once, as long as their contexts differ. Matching therefore uses the full tag, and separate iterations of the same code fire independently. Each two-operand token carries a side bit, 0 for left and 1 for right. Packets always present the left operand and the right operand in fixed fields, whichever of the two arrived first.

Tokens enter over a valid/ready handshake. A token is taken on a clock edge where `tok_valid` and `tok_ready` are both high. `tok_ready` may depend on the token currently offered, so a producer must hold its token stable until it is accepted. Packets leave from a single output register over a valid/ready handshake. The register holds its packet while `pkt_ready` is low. A new packet can load in the same cycle that the old one is taken.

Top module: `tok_match_unit`

## Requirements
- R1: After reset, `pkt_valid` and `dup_err` are low, the store is empty, and a two-operand token is offered `tok_ready` high.
- R2: A token with `tok_single`=1 yields a packet in the cycle after acceptance. The packet has `pkt_left` equal to the token value, `pkt_right` equal to 0, and the token's address and context. The store is not touched.
- R3: A two-operand token whose tag has no waiting partner is stored and produces no packet.
- R4: A two-operand token whose tag matches a waiting entry of the opposite side yields a packet one cycle after acceptance. `pkt_left` carries the side-0 value and `pkt_right` carries the side-1 value, whichever arrived first. The waiting entry is freed.
- R5: Tags that share an address but differ in context are held and matched independently. At most one waiting entry exists per tag.
- R6: The store holds ENTRIES operands. When it is full, a token that would need a new entry sees `tok_ready` low until an entry frees. A token that matches a waiting entry is still accepted while the store is full.
- R7: A two-operand token whose tag and side equal a waiting entry raises `dup_err` for exactly the cycle after acceptance and is dropped. The waiting entry keeps its original value.
- R8: While `pkt_valid` is high and `pkt_ready` is low, the packet fields stay stable. Any token that needs the output (single-operand or matching) sees `tok_ready` low. Tokens that only need a store entry are still accepted.
- R9: With `pkt_ready` high and store space available, one token is accepted every cycle, and back-to-back matches emit one packet per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token offered |
| tok_ready | output | 1 | Token can be taken this cycle |
| tok_addr | input | ADDR_W | Destination instruction address |
| tok_ctx | input | CTX_W | Context number |
| tok_side | input | 1 | Operand side: 0 left, 1 right |
| tok_single | input | 1 | 1 when the instruction takes one operand |
| tok_value | input | VAL_W | Operand value |
| pkt_valid | output | 1 | Enabled packet present |
| pkt_ready | input | 1 | Consumer takes the packet |
| pkt_addr | output | ADDR_W | Packet instruction address |
| pkt_ctx | output | CTX_W | Packet context |
| pkt_left | output | VAL_W | Left operand (or sole operand) |
| pkt_right | output | VAL_W | Right operand (0 for single-operand packets) |
| dup_err | output | 1 | One-cycle pulse: duplicate operand dropped |

## Verification
Two coincidences are provoked.

The first is a match arriving while the store is full. Every entry is filled with left operands that differ only in context. The bench confirms that a fresh tag is refused. It then offers a right partner in the same full state and checks that the partner is accepted and paired. Finally, it checks that the freed slot takes the previously refused tag.

The second is a packet load in the same cycle as output back-pressure or drain. With `pkt_ready` held low, the bench checks three things: a single-operand token is refused, a storing token still enters, and the held packet stays unchanged. It then releases `pkt_ready` and judges the drain and the next packet.

// File: rtl/tm_pkg.sv
package tm_pkg;
  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  localparam int DEF_ADDR_W  = 6;
  localparam int DEF_CTX_W   = 4;
  localparam int DEF_VAL_W   = 16;
  localparam int DEF_ENTRIES = 8;
endpackage

// File: rtl/tm_lowest.sv
module tm_lowest #(
  parameter int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tm_store.sv
module tm_store
  import tm_pkg::*;
#(
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int TAG_W   = DEF_ADDR_W + DEF_CTX_W,
  parameter int VAL_W   = DEF_VAL_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TAG_W-1:0]   look_tag,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  side_e              wr_side,
  input  logic [VAL_W-1:0]   wr_val,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [ENTRIES-1:0] used_vec,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] side_vec,
  output logic [VAL_W-1:0]   val_arr [ENTRIES]
);
  logic [TAG_W-1:0] tag_arr [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used_vec[e] <= 1'b0;
        tag_arr[e]  <= '0;
        side_vec[e] <= 1'b0;
        val_arr[e]  <= '0;
      end else if (wr_en && wr_idx == IDX_W'(e)) begin
        used_vec[e] <= 1'b1;
        tag_arr[e]  <= wr_tag;
        side_vec[e] <= wr_side;
        val_arr[e]  <= wr_val;
      end else if (clr_en && clr_idx == IDX_W'(e)) begin
        used_vec[e] <= 1'b0;
      end
    end

    // associative compare of the full tag, one per entry
    assign hit_vec[e] = used_vec[e] && (tag_arr[e] == look_tag);
  end
endmodule

// File: rtl/tm_out_stage.sv
module tm_out_stage #(
  parameter int ADDR_W = 6,
  parameter int CTX_W  = 4,
  parameter int VAL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CTX_W-1:0]  ld_ctx,
  input  logic [VAL_W-1:0]  ld_left,
  input  logic [VAL_W-1:0]  ld_right,
  output logic              can_load,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [ADDR_W-1:0] pkt_addr,
  output logic [CTX_W-1:0]  pkt_ctx,
  output logic [VAL_W-1:0]  pkt_left,
  output logic [VAL_W-1:0]  pkt_right
);
  assign can_load = !pkt_valid || pkt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_valid <= 1'b0;
      pkt_addr  <= '0;
      pkt_ctx   <= '0;
      pkt_left  <= '0;
      pkt_right <= '0;
    end else if (load && can_load) begin
      pkt_valid <= 1'b1;
      pkt_addr  <= ld_addr;
      pkt_ctx   <= ld_ctx;
      pkt_left  <= ld_left;
      pkt_right <= ld_right;
    end else if (pkt_ready) begin
      pkt_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tok_match_unit.sv
module tok_match_unit
  import tm_pkg::*;
#(
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int CTX_W   = DEF_CTX_W,
  parameter int VAL_W   = DEF_VAL_W,
  parameter int ENTRIES = DEF_ENTRIES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  output logic              tok_ready,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [CTX_W-1:0]  tok_ctx,
  input  logic              tok_side,
  input  logic              tok_single,
  input  logic [VAL_W-1:0]  tok_value,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [ADDR_W-1:0] pkt_addr,
  output logic [CTX_W-1:0]  pkt_ctx,
  output logic [VAL_W-1:0]  pkt_left,
  output logic [VAL_W-1:0]  pkt_right,
  output logic              dup_err
);
  localparam int TAG_W = ADDR_W + CTX_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [TAG_W-1:0]   tag_in;
  logic [ENTRIES-1:0] used_vec, hit_vec, side_vec;
  logic [VAL_W-1:0]   val_arr [ENTRIES];
  logic [IDX_W-1:0]   hit_idx, free_idx;
  logic               hit_any, free_any, can_load;
  logic               is_dup, is_match, is_miss, need_out, accept;
  logic [VAL_W-1:0]   partner_val;
  logic [VAL_W-1:0]   ld_left, ld_right;
  side_e              side_in;

  assign tag_in  = {tok_addr, tok_ctx};
  assign side_in = side_e'(tok_side);

  tm_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .VAL_W(VAL_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_tag (tag_in),
    .wr_en    (accept && is_miss),
    .wr_idx   (free_idx),
    .wr_tag   (tag_in),
    .wr_side  (side_in),
    .wr_val   (tok_value),
    .clr_en   (accept && is_match),
    .clr_idx  (hit_idx),
    .used_vec (used_vec),
    .hit_vec  (hit_vec),
    .side_vec (side_vec),
    .val_arr  (val_arr)
  );

  tm_lowest #(.N(ENTRIES)) u_hit_enc (
    .vec (hit_vec),
    .idx (hit_idx),
    .any (hit_any)
  );

  tm_lowest #(.N(ENTRIES)) u_free_enc (
    .vec (~used_vec),
    .idx (free_idx),
    .any (free_any)
  );

  assign partner_val = val_arr[hit_idx];

  // classify the offered token
  always_comb begin
    is_match = !tok_single && hit_any && (side_vec[hit_idx] != tok_side);
    is_dup   = !tok_single && hit_any && (side_vec[hit_idx] == tok_side);
    is_miss  = !tok_single && !hit_any;
    need_out = tok_single || is_match;
    if (need_out)     tok_ready = can_load;
    else if (is_miss) tok_ready = free_any;
    else              tok_ready = 1'b1;
  end

  assign accept = tok_valid && tok_ready;

  // order operands by side, not by arrival
  always_comb begin
    if (tok_single) begin
      ld_left  = tok_value;
      ld_right = '0;
    end else if (side_in == SIDE_RIGHT) begin
      ld_left  = partner_val;
      ld_right = tok_value;
    end else begin
      ld_left  = tok_value;
      ld_right = partner_val;
    end
  end

  tm_out_stage #(.ADDR_W(ADDR_W), .CTX_W(CTX_W), .VAL_W(VAL_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && need_out),
    .ld_addr   (tok_addr),
    .ld_ctx    (tok_ctx),
    .ld_left   (ld_left),
    .ld_right  (ld_right),
    .can_load  (can_load),
    .pkt_valid (pkt_valid),
    .pkt_ready (pkt_ready),
    .pkt_addr  (pkt_addr),
    .pkt_ctx   (pkt_ctx),
    .pkt_left  (pkt_left),
    .pkt_right (pkt_right)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dup_err <= 1'b0;
    else        dup_err <= accept && is_dup;
  end
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
  parameter int ADDR_W  = 6,
  parameter int CTX_W   = 4,
  parameter int VAL_W   = 16,
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tok_valid,
  input logic               tok_ready,
  input logic               tok_single,
  input logic [VAL_W-1:0]   tok_value,
  input logic               pkt_valid,
  input logic               pkt_ready,
  input logic [ADDR_W-1:0]  pkt_addr,
  input logic [CTX_W-1:0]   pkt_ctx,
  input logic [VAL_W-1:0]   pkt_left,
  input logic [VAL_W-1:0]   pkt_right,
  input logic               dup_err,
  input logic [ENTRIES-1:0] used_vec,
  input logic [ENTRIES-1:0] hit_vec
);
  assert_tag_unique_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !tok_single && (&used_vec) && (hit_vec == '0)) |-> !tok_ready);

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=>
      (pkt_valid && $stable(pkt_left) && $stable(pkt_right)
       && $stable(pkt_addr) && $stable(pkt_ctx)));

  assert_dup_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |-> $past(tok_valid && tok_ready && !tok_single));

  assert_single_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready && tok_single) |=>
      (pkt_valid && pkt_left == $past(tok_value) && pkt_right == '0));
endmodule

bind tok_match_unit tm_checker #(
  .ADDR_W(ADDR_W), .CTX_W(CTX_W), .VAL_W(VAL_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tok_valid  (tok_valid),
  .tok_ready  (tok_ready),
  .tok_single (tok_single),
  .tok_value  (tok_value),
  .pkt_valid  (pkt_valid),
  .pkt_ready  (pkt_ready),
  .pkt_addr   (pkt_addr),
  .pkt_ctx    (pkt_ctx),
  .pkt_left   (pkt_left),
  .pkt_right  (pkt_right),
  .dup_err    (dup_err),
  .used_vec   (used_vec),
  .hit_vec    (hit_vec)
);

// File: tb/sim_tok_match_unit.sv
`timescale 1ns/1ps
module sim_tok_match_unit;
  localparam int ADDR_W = 6, CTX_W = 4, VAL_W = 16, ENTRIES = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tok_valid = 1'b0, tok_side = 1'b0, tok_single = 1'b0, pkt_ready = 1'b1;
  logic [ADDR_W-1:0] tok_addr = '0;
  logic [CTX_W-1:0]  tok_ctx = '0;
  logic [VAL_W-1:0]  tok_value = '0;
  logic tok_ready, pkt_valid, dup_err;
  logic [ADDR_W-1:0] pkt_addr;
  logic [CTX_W-1:0]  pkt_ctx;
  logic [VAL_W-1:0]  pkt_left, pkt_right;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  tok_match_unit #(.ADDR_W(ADDR_W), .CTX_W(CTX_W), .VAL_W(VAL_W), .ENTRIES(ENTRIES)) u0 (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_addr(tok_addr), .tok_ctx(tok_ctx), .tok_side(tok_side),
    .tok_single(tok_single), .tok_value(tok_value), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_addr(pkt_addr), .pkt_ctx(pkt_ctx),
    .pkt_left(pkt_left), .pkt_right(pkt_right), .dup_err(dup_err)
  );

  function automatic logic [VAL_W-1:0] lval(input int c);
    return VAL_W'(16'h1000 + c * 3);
  endfunction
  function automatic logic [VAL_W-1:0] rval(input int c);
    return VAL_W'(16'h2000 ^ (c * 7));
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input int a, input int c, input logic s, input logic one, input logic [VAL_W-1:0] v);
    tok_addr = ADDR_W'(a); tok_ctx = CTX_W'(c); tok_side = s;
    tok_single = one; tok_value = v; tok_valid = 1'b1;
  endtask

  // offer at negedge, wait for acceptance, return at the following negedge
  task automatic send(input int a, input int c, input logic s, input logic one,
                      input logic [VAL_W-1:0] v, output int waited);
    drive(a, c, s, one, v);
    waited = 0;
    #1;
    while (!tok_ready) begin
      @(negedge clk); #1; waited++;
    end
    @(posedge clk);
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic probe(input int a, input int c, input logic s, input logic one, output logic rdy);
    drive(a, c, s, one, '0);
    #1;
    rdy = tok_ready;
    tok_valid = 1'b0;
    #1;
  endtask

  task automatic expect_pkt(input string req, input int a, input int c,
                            input logic [VAL_W-1:0] l, input logic [VAL_W-1:0] r);
    chk(req, "pkt_valid", 32'(pkt_valid), 32'd1);
    chk(req, "pkt_addr", 32'(pkt_addr), 32'(a));
    chk(req, "pkt_ctx", 32'(pkt_ctx), 32'(c));
    chk(req, "pkt_left", 32'(pkt_left), 32'(l));
    chk(req, "pkt_right", 32'(pkt_right), 32'(r));
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w;
    logic rdy;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "pkt_valid", 32'(pkt_valid), 32'd0);
    chk("R1", "dup_err", 32'(dup_err), 32'd0);
    chk("R1", "tok_ready", 32'(tok_ready), 32'd1);
    @(negedge clk);

    // R2: single-operand tokens pass through
    for (int i = 0; i < 6; i++) begin
      send(i + 1, i, 1'(i % 2), 1'b1, VAL_W'(16'hA000 + i * 37), w);
      expect_pkt("R2", i + 1, i, VAL_W'(16'hA000 + i * 37), '0);
    end
    @(negedge clk);
    chk("R2", "drained", 32'(pkt_valid), 32'd0);

    // R3 R5: fill store with left operands differing only in context
    for (int c = 0; c < ENTRIES; c++) begin
      send(5, c, 1'b0, 1'b0, lval(c), w);
      chk("R3", "no packet on store", 32'(pkt_valid), 32'd0);
      chk("R3", "no dup", 32'(dup_err), 32'd0);
    end
    // R6: full store refuses a new tag
    probe(5, ENTRIES, 1'b0, 1'b0, rdy);
    chk("R6", "full refuses new tag", 32'(rdy), 32'd0);
    // R6: a matching partner is accepted while full
    @(negedge clk);
    send(5, 3, 1'b1, 1'b0, rval(3), w);
    expect_pkt("R6", 5, 3, lval(3), rval(3));
    probe(5, ENTRIES, 1'b0, 1'b0, rdy);
    chk("R6", "freed slot accepts", 32'(rdy), 32'd1);
    @(negedge clk);
    send(5, ENTRIES, 1'b0, 1'b0, lval(ENTRIES), w);
    chk("R6", "stored no packet", 32'(pkt_valid), 32'd0);
    // R5: drain in reverse context order
    for (int c = ENTRIES; c >= 0; c--) begin
      if (c != 3) begin
        send(5, c, 1'b1, 1'b0, rval(c), w);
        expect_pkt("R5", 5, c, lval(c), rval(c));
      end
    end
    @(negedge clk);

    // R4: right side first, operands still ordered by side
    send(12, 1, 1'b1, 1'b0, 16'h0BEE, w);
    chk("R4", "first no packet", 32'(pkt_valid), 32'd0);
    send(12, 1, 1'b0, 1'b0, 16'h0A11, w);
    expect_pkt("R4", 12, 1, 16'h0A11, 16'h0BEE);
    @(negedge clk);

    // R7: duplicate operand dropped, original kept
    send(9, 2, 1'b0, 1'b0, 16'h0111, w);
    send(9, 2, 1'b0, 1'b0, 16'h0222, w);
    chk("R7", "dup_err pulse", 32'(dup_err), 32'd1);
    chk("R7", "no packet", 32'(pkt_valid), 32'd0);
    @(negedge clk);
    chk("R7", "dup_err one cycle", 32'(dup_err), 32'd0);
    send(9, 2, 1'b1, 1'b0, 16'h0333, w);
    expect_pkt("R7", 9, 2, 16'h0111, 16'h0333);
    @(negedge clk);

    // R8: output back-pressure
    pkt_ready = 1'b0;
    send(20, 4, 1'b0, 1'b1, 16'h5A5A, w);
    expect_pkt("R8", 20, 4, 16'h5A5A, '0);
    probe(21, 4, 1'b0, 1'b1, rdy);
    chk("R8", "single refused while held", 32'(rdy), 32'd0);
    @(negedge clk);
    send(22, 6, 1'b0, 1'b0, 16'h0C0C, w);
    chk("R8", "storing token no wait", 32'(w), 32'd0);
    expect_pkt("R8", 20, 4, 16'h5A5A, '0);
    pkt_ready = 1'b1;
    @(negedge clk);
    chk("R8", "drained after release", 32'(pkt_valid), 32'd0);
    send(22, 6, 1'b1, 1'b0, 16'h0D0D, w);
    expect_pkt("R8", 22, 6, 16'h0C0C, 16'h0D0D);

    // R9: back-to-back accept, one packet per match cycle
    for (int k = 0; k < 4; k++) begin
      send(30 + k, k, 1'b0, 1'b0, lval(k + 40), w);
      chk("R9", "no stall store", 32'(w), 32'd0);
      send(30 + k, k, 1'b1, 1'b0, rval(k + 40), w);
      chk("R9", "no stall match", 32'(w), 32'd0);
      expect_pkt("R9", 30 + k, k, lval(k + 40), rval(k + 40));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule